// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Mode Latch

This block is the test access port of a device that has two independent resets: a test reset, active low and sampled only on rising edges of the test clock, and a core reset. It runs the standard sixteen-state test controller. It holds an instruction register, a one-bit bypass path and a 32-bit identification register. Test data enters on TDI and leaves on TDO. TDO is driven only while a register is being shifted.

When the test reset goes from low to high, the block captures two mode-select pins. It captures them only if the core reset has already been released. The captured value tells the rest of the device whether to run in boundary-scan mode or in emulation mode. The identification word is built from a variant field, a part number and a manufacturer code. Its variant field carries the real value only while the core reset is released, and it reads as zero while the core is held in reset.

The test reset input is meant to default low when nothing drives it. Holding it low keeps the port and the mode latch in reset while the rest of the chip runs.

Top module: `tap_port`

## Requirements
- R1: The test reset (`testRstN` low) acts only at a `tck` rising edge. At such an edge the controller goes to Test-Logic-Reset and the instruction becomes IDCODE. Lowering `testRstN` while `tck` is stopped changes no output.
- R2: While `testRstN` stays low, `tdoOe` stays 0 and `modeOut` reads 0 whatever `tms` does.
- R3: `modeOut` loads `modeIn` at the first `tck` rising edge that samples `testRstN` high after it was sampled low, provided `coreRstN` is high. If `coreRstN` is low at that edge, `modeOut` stays 0.
- R4: Apart from the edges named in R3, `modeOut` changes only when it is cleared by the test reset.
- R5: The controller follows the standard sixteen-state sequence on `tck` rising edges. Five edges with `tms` high reach Test-Logic-Reset from any state, and that reset restores the IDCODE instruction.
- R6: IDCODE is the instruction after reset. It shifts out the 32-bit word {variant[31:28], part[27:12], manufacturer[11:1], 1'b1}, which is 0x0007902F with the default parameters (variant 0, part 0x0079, manufacturer 0x017).
- R7: The variant field is loaded with `ID_VARIANT` only when `coreRstN` is high at Capture-DR. Otherwise it is loaded with zeros.
- R8: In Capture-IR the instruction shift register loads the pattern with bit 0 = 1, bit 1 = 0 and all other bits 0.
- R9: The all-ones opcode selects the one-bit bypass register. It captures 0 in Capture-DR and passes TDI to TDO one shift later.
- R10: Every opcode other than IDCODE (`OP_IDCODE`, default 4'b0010) and all-ones also selects the bypass register.
- R11: TDO and its enable change on `tck` falling edges. `tdoOe` is 1 exactly in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdoOe` is 0.
- R12: Both registers shift least significant bit first: TDI enters at the most significant end and TDO shows bit 0.
- R13: Every instruction other than IDCODE behaves the same whether `coreRstN` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on tck rising edge |
| tdi | input | 1 | Serial test data in |
| testRstN | input | 1 | Test reset, active low, synchronous to tck |
| coreRstN | input | 1 | Core reset, active low, level only |
| modeIn | input | MODE_W | Mode-select pins |
| tdo | output | 1 | Serial test data out, updated on tck falling edge |
| tdoOe | output | 1 | Output enable for tdo |
| modeOut | output | MODE_W | Mode value latched at test reset release |

## Verification
Two functions share one `tck` edge: the release of the test reset, and both the first controller transition out of reset and the mode capture, which depends on the core reset level at that same edge. The bench provokes this edge for every mode-pin value with the core reset both high and low. It judges the result from `modeOut` right after the edge and from its stability over the following cycles. A second coincidence is the Capture-DR edge, which samples the core reset level when building the identification word. The bench sweeps every opcode under both core reset levels, on two instances that differ in their variant value, and predicts the whole shifted stream arithmetically.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_t;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
  } tapStrobe_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       tms,
  input  logic       testRstN,
  output tapState_t  stateQ,
  output tapStrobe_t strobe
);

  tapState_t stateNext;

  always_comb begin
    case (stateQ)
      ST_TLR:    stateNext = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    stateNext = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: stateNext = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  stateNext = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: stateNext = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: stateNext = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: stateNext = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: stateNext = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: stateNext = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  stateNext = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: stateNext = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: stateNext = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: stateNext = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: stateNext = tms ? ST_SEL_DR : ST_RTI;
      default:   stateNext = ST_TLR;
    endcase
  end

  // Test reset is sampled on the clock edge only; nothing happens without tck.
  always_ff @(posedge tck) begin
    if (!testRstN) stateQ <= ST_TLR;
    else           stateQ <= stateNext;
  end

  always_comb begin
    strobe.inReset   = (stateQ == ST_TLR);
    strobe.captureIr = (stateQ == ST_CAP_IR);
    strobe.shiftIr   = (stateQ == ST_SH_IR);
    strobe.updateIr  = (stateQ == ST_UPD_IR);
    strobe.captureDr = (stateQ == ST_CAP_DR);
    strobe.shiftDr   = (stateQ == ST_SH_DR);
  end

endmodule

// File: rtl/tap_mode_latch.sv
module tap_mode_latch #(
  parameter int MODE_W = 2
) (
  input  logic              tck,
  input  logic              testRstN,
  input  logic              coreRstN,
  input  logic [MODE_W-1:0] modeIn,
  output logic [MODE_W-1:0] modeQ
);

  logic trstSeenQ;

  always_ff @(posedge tck) begin
    trstSeenQ <= testRstN;
  end

  // Capture only on the release edge, and only once the core is out of reset.
  always_ff @(posedge tck) begin
    if (!testRstN)                  modeQ <= '0;
    else if (!trstSeenQ && coreRstN) modeQ <= modeIn;
  end

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter logic [IR_W-1:0] OP_IDCODE  = 4'b0010,
  parameter logic [3:0]      ID_VARIANT = 4'h0,
  parameter logic [15:0]     ID_PART    = 16'h0079,
  parameter logic [10:0]     ID_MANUF   = 11'h017
) (
  input  logic       tck,
  input  logic       tdi,
  input  logic       testRstN,
  input  logic       coreRstN,
  input  tapStrobe_t strobe,
  output logic       tdo,
  output logic       tdoOe
);

  localparam int              ID_W       = 32;
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] irShiftQ;
  logic [IR_W-1:0] irQ;
  logic [ID_W-1:0] idShiftQ;
  logic            bypassQ;
  logic            selId;
  logic [ID_W-1:0] idWord;

  assign selId  = (irQ == OP_IDCODE);
  assign idWord = {(coreRstN ? ID_VARIANT : 4'h0), ID_PART, ID_MANUF, 1'b1};

  always_ff @(posedge tck) begin
    if (!testRstN || strobe.inReset) irQ <= OP_IDCODE;
    else if (strobe.updateIr)        irQ <= irShiftQ;
  end

  always_ff @(posedge tck) begin
    if (strobe.captureIr)    irShiftQ <= IR_CAPTURE;
    else if (strobe.shiftIr) irShiftQ <= {tdi, irShiftQ[IR_W-1:1]};
  end

  always_ff @(posedge tck) begin
    if (selId) begin
      if (strobe.captureDr)    idShiftQ <= idWord;
      else if (strobe.shiftDr) idShiftQ <= {tdi, idShiftQ[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (!selId) begin
      if (strobe.captureDr)    bypassQ <= 1'b0;
      else if (strobe.shiftDr) bypassQ <= tdi;
    end
  end

  // Output stage retimed to the falling edge.
  always_ff @(negedge tck) begin
    tdoOe <= strobe.shiftIr | strobe.shiftDr;
    if (strobe.shiftIr)      tdo <= irShiftQ[0];
    else if (strobe.shiftDr) tdo <= selId ? idShiftQ[0] : bypassQ;
    else                     tdo <= 1'b0;
  end

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter int              MODE_W     = 2,
  parameter logic [IR_W-1:0] OP_IDCODE  = 4'b0010,
  parameter logic [3:0]      ID_VARIANT = 4'h0,
  parameter logic [15:0]     ID_PART    = 16'h0079,
  parameter logic [10:0]     ID_MANUF   = 11'h017
) (
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              testRstN,
  input  logic              coreRstN,
  input  logic [MODE_W-1:0] modeIn,
  output logic              tdo,
  output logic              tdoOe,
  output logic [MODE_W-1:0] modeOut
);

  tapState_t  stateQ;
  tapStrobe_t strobe;

  tap_ctrl ctrl_i (
    .tck      (tck),
    .tms      (tms),
    .testRstN (testRstN),
    .stateQ   (stateQ),
    .strobe   (strobe)
  );

  tap_datapath #(
    .IR_W       (IR_W),
    .OP_IDCODE  (OP_IDCODE),
    .ID_VARIANT (ID_VARIANT),
    .ID_PART    (ID_PART),
    .ID_MANUF   (ID_MANUF)
  ) dp_i (
    .tck      (tck),
    .tdi      (tdi),
    .testRstN (testRstN),
    .coreRstN (coreRstN),
    .strobe   (strobe),
    .tdo      (tdo),
    .tdoOe    (tdoOe)
  );

  tap_mode_latch #(.MODE_W(MODE_W)) mode_i (
    .tck      (tck),
    .testRstN (testRstN),
    .coreRstN (coreRstN),
    .modeIn   (modeIn),
    .modeQ    (modeOut)
  );

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
  import tap_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input logic              tck,
  input logic              tms,
  input logic              testRstN,
  input logic              tdo,
  input logic              tdoOe,
  input tapState_t         tapState,
  input logic [MODE_W-1:0] modeOut
);

  assert_reset_tlr_R1: assert property (@(posedge tck) disable iff (!testRstN)
    !$past(testRstN) |-> tapState == ST_TLR);

  assert_mode_hold_R4: assert property (@(posedge tck) disable iff (!testRstN)
    ($past(testRstN) && $past(testRstN, 2)) |-> $stable(modeOut));

  assert_five_high_R5: assert property (@(posedge tck) disable iff (!testRstN)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> tapState == ST_TLR);

  assert_oe_shift_R11: assert property (@(posedge tck) disable iff (!testRstN)
    tdoOe == (tapState == ST_SH_IR || tapState == ST_SH_DR));

  assert_tdo_quiet_R11: assert property (@(posedge tck) disable iff (!testRstN)
    !tdoOe |-> !tdo);

endmodule

bind tap_port tap_port_chk #(.MODE_W(MODE_W)) chk_i (
  .tck      (tck),
  .tms      (tms),
  .testRstN (testRstN),
  .tdo      (tdo),
  .tdoOe    (tdoOe),
  .tapState (stateQ),
  .modeOut  (modeOut)
);

// File: tb/tap_port_tb_top.sv
`timescale 1ns/1ps
module tap_port_tb_top;

  localparam int         IR_W    = 4;
  localparam logic [3:0] OP_ID   = 4'b0010;
  localparam logic [3:0] VAR_ALT = 4'h9;

  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic testRstN = 1'b0, coreRstN = 1'b0, clkRun = 1'b1;
  logic [1:0] modeIn = 2'b00;
  logic tdoA, tdoOeA, tdoB, tdoOeB;
  logic [1:0] modeA, modeB;
  int checks = 0, errors = 0;
  bit done = 0;

  always begin
    #2.5;
    if (clkRun) tck = ~tck;
  end

  tap_port dut_i (
    .tck(tck), .tms(tms), .tdi(tdi), .testRstN(testRstN), .coreRstN(coreRstN),
    .modeIn(modeIn), .tdo(tdoA), .tdoOe(tdoOeA), .modeOut(modeA));

  tap_port #(.ID_VARIANT(VAR_ALT)) dutVar_i (
    .tck(tck), .tms(tms), .tdi(tdi), .testRstN(testRstN), .coreRstN(coreRstN),
    .modeIn(modeIn), .tdo(tdoB), .tdoOe(tdoOeB), .modeOut(modeB));

  function automatic logic [31:0] idFor(input logic [3:0] v);
    return {v, 16'h0079, 11'h017, 1'b1};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sample outputs for the current state, drive next inputs, and re-sample after the rising edge.
  task automatic step(input logic tmsV, input logic tdiV,
                      output logic a, output logic b, output logic ea, output logic eb,
                      output logic pa);
    @(negedge tck); #1;
    a = tdoA; b = tdoB; ea = tdoOeA; eb = tdoOeB;
    tms = tmsV; tdi = tdiV;
    @(posedge tck); #0.5;
    pa = tdoA;
  endtask

  task automatic go(input logic tmsV);
    logic a, b, ea, eb, pa;
    step(tmsV, 1'b0, a, b, ea, eb, pa);
  endtask

  task automatic scanDr(input logic [63:0] din, input int n,
                        output logic [63:0] outA, output logic [63:0] outB,
                        output bit oeOk, output bit holdOk);
    logic a, b, ea, eb, pa;
    go(1); go(0); go(0);
    outA = '0; outB = '0; oeOk = 1; holdOk = 1;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], a, b, ea, eb, pa);
      outA[i] = a; outB[i] = b;
      if (!(ea && eb)) oeOk = 0;
      if (pa !== a) holdOk = 0;
    end
    step(1, 0, a, b, ea, eb, pa);
    if (ea || eb || a || b) oeOk = 0;
    go(0);
  endtask

  task automatic scanIr(input logic [IR_W-1:0] op, output logic [IR_W-1:0] capA);
    logic a, b, ea, eb, pa;
    go(1); go(1); go(0); go(0);
    capA = '0;
    for (int i = 0; i < IR_W; i++) begin
      step(i == IR_W - 1, op[i], a, b, ea, eb, pa);
      capA[i] = a;
    end
    go(1); go(0);
  endtask

  task automatic applyTrst(input logic coreV, input logic [1:0] modeV);
    @(negedge tck); #1;
    testRstN = 0; tms = 0;
    @(posedge tck); @(posedge tck);
    @(negedge tck); #1;
    coreRstN = coreV; modeIn = modeV; testRstN = 1;
    @(posedge tck); #1;
  endtask

  initial begin
    logic [63:0] outA, outB, din, expA, expB, mask;
    logic [IR_W-1:0] cap;
    bit oeOk, holdOk, r2ok;
    mask = (64'd1 << 40) - 64'd1;

    // R2: held in test reset while tms toggles
    r2ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge tck); #1;
      tms = i[0]; modeIn = 2'(i);
      if (i > 1 && (tdoOeA !== 1'b0 || tdoOeB !== 1'b0 || modeA !== 2'b00 || modeB !== 2'b00)) r2ok = 0;
    end
    chk("R2 reset-held outputs", 64'(r2ok), 64'd1);

    // R3/R4: mode capture across all pin values and both core reset levels
    for (int core = 0; core < 2; core++) begin
      for (int m = 0; m < 4; m++) begin
        applyTrst(core[0], 2'(m));
        chk("R3 mode capture A", 64'(modeA), core ? 64'(m) : 64'd0);
        chk("R3 mode capture B", 64'(modeB), core ? 64'(m) : 64'd0);
        modeIn = ~2'(m);
        coreRstN = 1;
        for (int k = 0; k < 4; k++) go(0);
        chk("R4 mode stable", 64'(modeA), core ? 64'(m) : 64'd0);
      end
    end

    // R1: test reset without clock has no effect until an edge
    applyTrst(1, 2'b10);
    chk("R1 preset mode", 64'(modeA), 64'h2);
    @(negedge tck); #1;
    clkRun = 0;
    testRstN = 0;
    #20;
    chk("R1 no clock no reset", 64'(modeA), 64'h2);
    clkRun = 1;
    @(posedge tck); #1;
    chk("R1 reset on edge", 64'(modeA), 64'h0);
    applyTrst(1, 2'b00);

    // R6/R12: default instruction is IDCODE
    coreRstN = 1;
    din = 64'h5A;
    scanDr(din, 40, outA, outB, oeOk, holdOk);
    chk("R6 default idcode", outA & mask, ((din << 32) | 64'(idFor(4'h0))) & mask);
    chk("R6 idcode value", outA[31:0], 64'h0007902F);
    chk("R12 lsb first", outA[3:0], 64'hF);
    chk("R7 variant released", outB[31:0], 64'(idFor(VAR_ALT)));

    // Opcode sweep under both core reset levels
    for (int core = 0; core < 2; core++) begin
      for (int op = 0; op < 16; op++) begin
        coreRstN = core[0];
        scanIr(4'(op), cap);
        chk("R8 ir capture", 64'(cap), 64'h1);
        din = 64'(8'hA5 ^ (8'(op) * 8'h11));
        scanDr(din, 40, outA, outB, oeOk, holdOk);
        if (4'(op) == OP_ID) begin
          expA = ((din << 32) | 64'(idFor(4'h0))) & mask;
          expB = ((din << 32) | 64'(idFor(core ? VAR_ALT : 4'h0))) & mask;
          chk("R6 idcode stream", outA & mask, expA);
          chk("R7 variant vs core reset", outB & mask, expB);
        end else begin
          expA = (din << 1) & mask;
          if (op == 15) chk("R9 bypass all-ones", outA & mask, expA);
          else          chk("R10 undecoded bypass", outA & mask, expA);
          chk("R13 bypass independent of core reset", outB & mask, expA);
        end
        chk("R11 enable during shift only", 64'(oeOk), 64'd1);
        chk("R11 tdo held across rising edge", 64'(holdOk), 64'd1);
      end
    end

    // R5: five tms-high edges return to reset from several states
    coreRstN = 1;
    for (int p = 0; p < 3; p++) begin
      scanIr(4'hF, cap);
      case (p)
        0: begin go(1); go(0); go(0); end
        1: begin go(1); go(1); go(0); go(0); go(1); go(0); end
        default: begin go(1); go(1); go(0); go(0); end
      endcase
      for (int k = 0; k < 5; k++) go(1);
      go(0);
      scanDr(64'h0, 32, outA, outB, oeOk, holdOk);
      chk("R5 five-high reset restores idcode", outA[31:0], 64'h0007902F);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule